// File: doc/BRIEF.md
# Scan-Tested Add/XOR Datapath

This block holds a small state register built from two W-bit halves. In normal operation, each enabled clock replaces the state with the output of a fixed combinational stage: the upper half becomes the sum of the two halves and the lower half becomes their XOR. Every state bit has a 2:1 multiplexer at its D input. When the shift control is set, the multiplexers chain all bits into a single serial register.

A built-in sequencer uses that chain to test the combinational stage. A start strobe makes it shift a stimulus vector into the chain. It then lets the registers capture the stage output for exactly one clock, and shifts the captured word out. Each bit that leaves the chain is compared with the matching bit of an expected vector, and the result is reported through a one-cycle done pulse and a pass flag. A second start strobe that arrives during the shift-out phase chains a new test straight after the current one. The next stimulus is already shifted in while the previous result is shifted out.

Top module: `scan_test_ctrl`

## Requirements
- R1: Synchronous active-high reset clears state_o to zero, drives done_o and pass_o low and returns the sequencer to idle.
- R2: While idle with func_en_i high, each clock loads state_o with {hi+lo (mod 2^W), hi^lo}, where hi = state_o[2W-1:W] and lo = state_o[W-1:0]. While idle with func_en_i low, state_o holds.
- R3: A start strobe accepted while idle latches stim_i. The sequencer then shifts the vector into the chain for exactly N = 2W clocks, most significant bit first, so the chain holds stim_i when capture begins.
- R4: After the load phase, shifting stops for exactly one clock. On that clock the chain captures the R2 function of its contents, whatever the level of func_en_i.
- R5: In the shift-out phase, bits leave from state bit N-1 downward. Each bit is compared with the matching bit of exp_i, which is sampled on the capture clock. pass_o is set only if all N bits match, and a mismatch in any single bit position gives a fail.
- R6: done_o is high for exactly one cycle, after the (2N+2)th rising edge counted from the edge that accepts the start strobe.
- R7: pass_o is cleared when a start strobe is accepted from idle. It is updated together with done_o and then holds until the next such clear or the next done_o.
- R8: During the shift-out phase, the chain is fed serially, most significant bit first, from the stim_i value sampled on the capture clock. After an unchained test, state_o therefore equals that vector.
- R9: A start strobe during the shift-out phase chains a new test. The capture of the chained test happens on the clock after done_o, and its done_o follows N+1 cycles after the first one.
- R10: A start strobe during the load phase or the capture clock is ignored. It neither extends nor repeats the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_en_i | input | 1 | Enables functional state updates while idle |
| start_i | input | 1 | Test start strobe |
| stim_i | input | 2W | Stimulus vector (also sampled at capture as the next vector) |
| exp_i | input | 2W | Expected captured vector, sampled at capture |
| state_o | output | 2W | Current contents of the state register / scan chain |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | Result of the last completed test |

## Verification
The hardest case to reach is a chained back-to-back test. The start strobe has to arrive while the first result is being shifted out, and stim_i and exp_i have to carry different vectors on the two capture clocks. The bench drives its inputs at exact cycle offsets from the accepted start, so it presents the next stimulus on the first capture clock and the next expected vector on the second. A sweep also flips each expected bit position in turn, so a mismatch occurs at every point of the shift-out order. Extra strobes are injected during loading and capture to show that they are ignored.

// File: rtl/scan_test_pkg.sv
package scan_test_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_LOAD   = 2'd1,
    SQ_CAPT   = 2'd2,
    SQ_UNLOAD = 2'd3
  } seq_state_e;
endpackage

// File: rtl/scan_func.sv
module scan_func #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] cur,
  output logic [2*W-1:0] nxt
);
  logic [W-1:0] hi, lo;
  assign hi  = cur[2*W-1:W];
  assign lo  = cur[W-1:0];
  assign nxt = {hi + lo, hi ^ lo};
endmodule

// File: rtl/scan_chain_dp.sv
module scan_chain_dp #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           load_en,
  input  logic           scan_in,
  output logic           scan_out,
  output logic [2*W-1:0] state_o
);
  localparam int N = 2 * W;

  logic [N-1:0] st_q;
  logic [N-1:0] nxt;
  logic [N-1:0] chain_d;

  scan_func #(.W(W)) func_i (
    .cur (st_q),
    .nxt (nxt)
  );

  // 2:1 mux in front of every state bit: functional value or chain neighbour
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_head
      assign chain_d[i] = shift_en ? scan_in : nxt[i];
    end else begin : g_body
      assign chain_d[i] = shift_en ? st_q[i-1] : nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (shift_en || load_en) begin
      st_q <= chain_d;
    end
  end

  assign scan_out = st_q[N-1];
  assign state_o  = st_q;

  // R2: with neither shifting nor loading, the state must not move
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load_en) |=> $stable(st_q));
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_test_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         func_en_i,
  input  logic         start_i,
  input  logic [N-1:0] stim_i,
  input  logic [N-1:0] exp_i,
  input  logic         scan_out,
  output logic         shift_en,
  output logic         load_en,
  output logic         scan_in,
  output logic         done_o,
  output logic         pass_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [N-1:0]  sreg_q;
  logic [N-1:0]  ereg_q;
  logic          fail_q, pend_q, done_q, pass_q;
  logic          last, miss;

  assign last     = (cnt_q == LAST);
  assign shift_en = (state_q == SQ_LOAD) || (state_q == SQ_UNLOAD);
  assign load_en  = (state_q == SQ_CAPT) || ((state_q == SQ_IDLE) && func_en_i);
  assign scan_in  = sreg_q[N-1];
  assign miss     = (state_q == SQ_UNLOAD) && (scan_out != ereg_q[N-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      sreg_q  <= '0;
      ereg_q  <= '0;
      fail_q  <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            state_q <= SQ_LOAD;
            sreg_q  <= stim_i;
            cnt_q   <= '0;
            pass_q  <= 1'b0;
          end
        end
        SQ_LOAD: begin
          sreg_q <= sreg_q << 1;
          cnt_q  <= cnt_q + CW'(1);
          if (last) begin
            cnt_q   <= '0;
            state_q <= SQ_CAPT;
          end
        end
        SQ_CAPT: begin
          sreg_q  <= stim_i;
          ereg_q  <= exp_i;
          fail_q  <= 1'b0;
          cnt_q   <= '0;
          state_q <= SQ_UNLOAD;
        end
        SQ_UNLOAD: begin
          sreg_q <= sreg_q << 1;
          ereg_q <= ereg_q << 1;
          cnt_q  <= cnt_q + CW'(1);
          if (miss)    fail_q <= 1'b1;
          if (start_i) pend_q <= 1'b1;
          if (last) begin
            cnt_q   <= '0;
            done_q  <= 1'b1;
            pass_q  <= !(fail_q || miss);
            pend_q  <= 1'b0;
            state_q <= (pend_q || start_i) ? SQ_CAPT : SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R6: done only ends a shift-out phase
  a_r6_done_after_unload: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(state_q) == SQ_UNLOAD));
  // R4: capture lasts exactly one clock
  a_r4_one_capture: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_CAPT) |=> (state_q == SQ_UNLOAD));
  // R10: loading runs to its end regardless of start_i
  a_r10_load_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_LOAD && !last) |=> (state_q == SQ_LOAD));
  // R7: result flag is stable mid-test
  a_r7_pass_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q != SQ_IDLE && !(state_q == SQ_UNLOAD && last)) |=> $stable(pass_q));
endmodule

// File: rtl/scan_test_ctrl.sv
module scan_test_ctrl #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           func_en_i,
  input  logic           start_i,
  input  logic [2*W-1:0] stim_i,
  input  logic [2*W-1:0] exp_i,
  output logic [2*W-1:0] state_o,
  output logic           done_o,
  output logic           pass_o
);
  localparam int N = 2 * W;

  logic shift_en, load_en, scan_in, scan_out;

  scan_seq #(.N(N)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .func_en_i (func_en_i),
    .start_i   (start_i),
    .stim_i    (stim_i),
    .exp_i     (exp_i),
    .scan_out  (scan_out),
    .shift_en  (shift_en),
    .load_en   (load_en),
    .scan_in   (scan_in),
    .done_o    (done_o),
    .pass_o    (pass_o)
  );

  scan_chain_dp #(.W(W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .load_en  (load_en),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .state_o  (state_o)
  );
endmodule

// File: tb/scan_test_ctrl_tb_top.sv
module scan_test_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 2 * W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         func_en = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] stim = '0;
  logic [N-1:0] expv = '0;
  logic [N-1:0] state;
  logic         done, pass;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_test_ctrl #(.W(W)) dut_i (
    .clk (clk), .rst (rst), .func_en_i (func_en), .start_i (start),
    .stim_i (stim), .exp_i (expv), .state_o (state), .done_o (done), .pass_o (pass)
  );

  function automatic logic [N-1:0] fx(input logic [N-1:0] s);
    logic [W-1:0] h, l;
    h = s[N-1:W];
    l = s[W-1:0];
    return {h + l, h ^ l};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_val);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_val);
    end
  endtask

  // Starts right after a negedge; returns right after a negedge
  task automatic run_one(input logic [N-1:0] s, input logic [N-1:0] e,
                         input logic [N-1:0] s_next, input bit poke);
    stim = s; expv = e; start = 1'b1;
    @(negedge clk);                 // accepting edge passed
    start = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (poke && k == 4) start = 1'b1;   // R10 strobe in load
      @(negedge clk);
      start = 1'b0;
    end
    stim = s_next;                  // sampled on the capture edge
    if (poke) start = 1'b1;         // R10 strobe on capture
    @(negedge clk);
    start = 1'b0;
    chk(pass == 1'b0, "R7 pass cleared during test", pass, 0);
    repeat (N - 1) @(negedge clk);
    chk(done == 1'b0, "R6 done not early", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R6 done timing", done, 1);
    chk(pass == (e == fx(s)), "R3 R5 pass result", pass, (e == fx(s)));
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
    chk(pass == (e == fx(s)), "R7 pass holds", pass, (e == fx(s)));
    chk(state == s_next, "R8 state after shift-out", state, s_next);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] lf, model, e, s1, s2, s3, e1, e2;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(state == '0, "R1 state reset", state, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(pass == 1'b0, "R1 pass reset", pass, 0);

    // R3 R5 R6 R7 R8 sweep, corner vectors first
    run_one(16'h0000, fx(16'h0000), 16'hFFFF, 1'b0);
    run_one(16'hFFFF, fx(16'hFFFF), 16'h0000, 1'b0);
    for (int i = 0; i < 160; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      e = fx(lf);
      if (i % 3 != 0) e = e ^ (16'h1 << (i % 16));   // R5 single-bit mismatch
      run_one(lf, e, lf ^ 16'h5A3C, 1'b0);
    end

    // R10: strobes in load and capture ignored
    run_one(16'h1234, fx(16'h1234), 16'hBEEF, 1'b1);
    repeat (N + 3) begin
      @(negedge clk);
      chk(done == 1'b0, "R10 no repeat test", done, 0);
    end
    chk(state == 16'hBEEF, "R10 state unchanged", state, 16'hBEEF);

    // R2: functional mode
    model = state;
    func_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      model = fx(model);
      chk(state == model, "R2 functional step", state, model);
    end
    func_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(state == model, "R2 hold when disabled", state, model);

    // R9: chained test, R4 capture with func_en high
    func_en = 1'b1;
    s1 = 16'h3C7A; e1 = fx(s1);
    s2 = 16'h81F0; e2 = fx(s2) ^ 16'h0100;
    s3 = 16'h6D29;
    stim = s1; expv = e1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N) @(negedge clk);
    stim = s2;                        // next stimulus on capture 1
    repeat (6) @(negedge clk);
    start = 1'b1;                     // strobe during shift-out
    @(negedge clk);
    start = 1'b0;
    repeat (N - 6) @(negedge clk);
    chk(done == 1'b1, "R9 first done", done, 1);
    chk(pass == 1'b1, "R4 R9 first pass", pass, 1);
    expv = e2; stim = s3;             // sampled on capture 2
    @(negedge clk);
    chk(done == 1'b0, "R9 capture follows done", done, 0);
    repeat (N - 1) @(negedge clk);
    chk(done == 1'b0, "R9 second done not early", done, 0);
    chk(pass == 1'b1, "R7 pass holds across chain", pass, 1);
    @(negedge clk);
    chk(done == 1'b1, "R9 second done timing", done, 1);
    chk(pass == 1'b0, "R9 second result fail", pass, 0);
    func_en = 1'b0;
    @(negedge clk);
    chk(state == s3, "R8 R9 state after chain", state, s3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule